// File: doc/BRIEF.md
# Two-Bit Mode-Configurable Carry Cell

This block is a purely combinational arithmetic slice with two bit positions: a lower half and an upper half. A 6-bit mode code selects one of 43 carry configurations. The families are add, subtract, add/subtract, increment, decrement, increment/decrement, and carry-forcing.

For each mode the block sets several things:
- the logic that forms each half's result bit;
- the carry passed from the lower half to the upper half, which is brought out on `mid_carry`;
- the carry leaving the cell on `chain_out`;
- the origin of the carry-in. This can be the chain input, the lower A pin, the inverse of the lower control pin, the lower control pin itself, or a constant.

Cells are meant to be stacked, with `chain_out` of one feeding `chain_in` of the next. The carry logic always uses its carries internally. The result-bit logic instead reads two routing pins as its carry term:
- `lo_sum_c` for the lower half. A user normally ties it to `chain_in`.
- `hi_sum_c` for the upper half. A user normally ties it to `mid_carry`.

Leaving these pins free lets the result logic be repurposed while the carry equations stay fixed. In one-bit modes the unused half's result output is driven to 0.

Top module: `dual_carry_slice`

## Requirements
Notation: the lower half is L, with A = `lo_a`, B = `lo_b`, control = `lo_ctl` and routing pin = `lo_sum_c`. The upper half is U, with A = `hi_a`, B = `hi_b`, control = `hi_ctl` and routing pin = `hi_sum_c`. The mode code is `mode`. The "carry into U" is `mid_carry`.

- R1: Add modes: 0 (L only, carry from `chain_in`), 1 (both halves, from `chain_in`), 2 (U only, from `lo_a`), 3 (U only, from `chain_in`), 4 (U only, from inverted `lo_ctl`). Each active half outputs A^B^pin. Its carry is (A&B)|(c&(A|B)).
- R2: Subtract modes: 5 (L, `chain_in`), 6 (both, `chain_in`), 7 (U, constant 1), 8 (U, `chain_in`), 9 (U, `lo_a`), 10 (U, inverted `lo_ctl`). A half outputs ~(A^B^pin) and carries (A&~B)|(c&(A|~B)); a carry of 1 means no borrow. Mode 7 outputs `hi_a`^`hi_b` and carries `hi_a`|~`hi_b`.
- R3: Add/subtract modes: 11 (L, `chain_in`), 12 (both, `chain_in`), 13 (U, `chain_in`), 14 (U, `lo_a`), 15 (U, inverted `lo_ctl`). `lo_ctl`=1 selects the add carry and `lo_ctl`=0 the subtract carry in both halves. A result bit is ~(A^B^pin^ctl), where ctl is `lo_ctl` for L and `hi_ctl` for U. In mode 15, `hi_out` = `hi_a`^`hi_b`, and `chain_out` is `hi_a`&`hi_b` when adding or `hi_a`|~`hi_b` when subtracting.
- R4: Increment modes: 16 (L, `chain_in`), 17 (both, constant 1), 18 (both, `chain_in`), 20 (U, `chain_in`), 21 (U, `lo_a`), 22 (U, inverted `lo_ctl`). A half outputs A^pin and carries A&c. In mode 17, `lo_out` = ~`lo_a` and `mid_carry` = `lo_a`.
- R5: Decrement modes: 23 (L, `chain_in`), 24 (both, constant 0), 25 (both, `chain_in`), 27 (U, `chain_in`), 28 (U, `lo_a`), 29 (U, inverted `lo_ctl`). A half outputs ~(A^pin) and carries A|c. In mode 24, `lo_out` = ~`lo_a` and `mid_carry` = `lo_a`.
- R6: Increment/decrement modes: 30 (L, `chain_in`), 31 (both, always enabled), 32 (both, `chain_in`), 34 (U, `chain_in`), 35 (U, `lo_a`). `lo_ctl`=1 selects increment and gives carry A&c; `lo_ctl`=0 selects decrement and gives carry A|c. A result bit is A^pin^~ctl, with ctl as in R3. In mode 31, `lo_out` = ~`lo_a` and `mid_carry` = `lo_a` for either direction.
- R7: In U-only modes, `mid_carry` equals the selected carry source. The sources are `chain_in`, `lo_a`, ~`lo_ctl`, or a constant. In L-only modes, `chain_out` equals `mid_carry`.
- R8: Forcing modes drive `lo_out` = `hi_out` = 0. Mode 36 gives `mid_carry` = `chain_out` = 0. Mode 37 gives 1 on both. Modes 38 and 42 give `chain_in` on both. Mode 39 gives `lo_a` on both. Mode 40 gives ~`lo_ctl` on both. Mode 41 gives `mid_carry` = 0 and `chain_out` = `hi_a`.
- R9: The always-enabled one-bit modes 19 (increment), 26 (decrement) and 33 (increment/decrement) are one function: `hi_out` = ~`hi_a`, `chain_out` = `hi_a` and `mid_carry` = 0, whatever the other inputs are.
- R10: In L-only modes (0, 5, 11, 16, 23, 30), `hi_out` is 0. In U-only modes (2–4, 7–10, 13–15, 19–22, 26–29, 33–35), `lo_out` is 0.
- R11: Codes 43 to 63 drive all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 6 | Configuration code (0–42 legal) |
| chain_in | input | 1 | Carry arriving from the neighbouring cell |
| lo_a | input | 1 | Lower A operand; also a carry source |
| lo_b | input | 1 | Lower B operand |
| lo_ctl | input | 1 | Direction control (1 = add/increment); inverted carry source |
| lo_sum_c | input | 1 | Carry term read by the lower result logic |
| hi_a | input | 1 | Upper A operand |
| hi_b | input | 1 | Upper B operand |
| hi_ctl | input | 1 | Direction control read by the upper result logic |
| hi_sum_c | input | 1 | Carry term read by the upper result logic |
| lo_out | output | 1 | Lower result bit |
| hi_out | output | 1 | Upper result bit |
| mid_carry | output | 1 | Carry between the halves |
| chain_out | output | 1 | Carry leaving the cell |

## Verification
The hardest cases to reach are the mismatched ones:
- the result-logic routing pins disagree with the internal carries;
- `hi_ctl` differs from `lo_ctl` in the add/subtract and increment/decrement modes.

In these cases the result bits and the carries follow separate terms. A bench that ties the routing pins the way a user would never shows the difference. The stimulus therefore sweeps all 64 mode codes against every one of the 512 combinations of the nine data inputs, which includes every mismatched setting. Each output is compared against a reference built directly from each mode's equations.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int MODE_W    = 6;
    localparam int NUM_MODES = 43;
    localparam int N_HALF    = 2;

    typedef enum logic [MODE_W-1:0] {
        M_ADD_LO_CI   = 6'd0,  M_ADD_PAIR_CI = 6'd1,  M_ADD_HI_P1   = 6'd2,
        M_ADD_HI_CI   = 6'd3,  M_ADD_HI_NP3  = 6'd4,
        M_SUB_LO_CI   = 6'd5,  M_SUB_PAIR_CI = 6'd6,  M_SUB_HI_ONE  = 6'd7,
        M_SUB_HI_CI   = 6'd8,  M_SUB_HI_P1   = 6'd9,  M_SUB_HI_NP3  = 6'd10,
        M_ADS_LO_CI   = 6'd11, M_ADS_PAIR_CI = 6'd12, M_ADS_HI_CI   = 6'd13,
        M_ADS_HI_P1   = 6'd14, M_ADS_HI_NP3  = 6'd15,
        M_INC_LO_CI   = 6'd16, M_INC_PAIR_1  = 6'd17, M_INC_PAIR_CI = 6'd18,
        M_INC_HI_ONE  = 6'd19, M_INC_HI_CI   = 6'd20, M_INC_HI_P1   = 6'd21,
        M_INC_HI_NP3  = 6'd22,
        M_DEC_LO_CI   = 6'd23, M_DEC_PAIR_0  = 6'd24, M_DEC_PAIR_CI = 6'd25,
        M_DEC_HI_ZERO = 6'd26, M_DEC_HI_CI   = 6'd27, M_DEC_HI_P1   = 6'd28,
        M_DEC_HI_NP3  = 6'd29,
        M_IDC_LO_CI   = 6'd30, M_IDC_PAIR_EN = 6'd31, M_IDC_PAIR_CI = 6'd32,
        M_IDC_HI_ZERO = 6'd33, M_IDC_HI_CI   = 6'd34, M_IDC_HI_P1   = 6'd35,
        M_PASS_ZERO   = 6'd36, M_PASS_ONE    = 6'd37, M_PASS_CI     = 6'd38,
        M_PASS_P1     = 6'd39, M_PASS_NP3    = 6'd40, M_PASS_HI_A   = 6'd41,
        M_PEEK_CI     = 6'd42
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_ADS, OP_INC, OP_DEC, OP_IDC
    } op_e;

    typedef enum logic [2:0] {
        SRC_CHAIN, SRC_LO_A, SRC_NCTL, SRC_CTL, SRC_ZERO, SRC_ONE
    } src_e;

    typedef struct packed {
        op_e  lo_op;
        op_e  hi_op;
        src_e src;
        logic lo_int;      // lower result uses internal carry, not routing pin
        logic hi_int;      // upper result uses internal carry, not routing pin
        logic hi_m_lo;     // upper result direction taken from lower control
        logic out_hi_a;    // cell carry-out driven from upper A
    } ctrl_t;

    typedef struct packed {
        logic lo_out;
        logic hi_out;
        logic mid;
        logic chain;
    } res_t;

endpackage

// File: rtl/dcs_mode_decode.sv
module dcs_mode_decode
    import dcs_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output ctrl_t             ctrl_o
);

    always_comb begin
        ctrl_o = '{lo_op: OP_NONE, hi_op: OP_NONE, src: SRC_ZERO,
                   lo_int: 1'b0, hi_int: 1'b0, hi_m_lo: 1'b0, out_hi_a: 1'b0};
        case (mode_i)
            M_ADD_LO_CI:   begin ctrl_o.lo_op = OP_ADD; ctrl_o.src = SRC_CHAIN; end
            M_ADD_PAIR_CI: begin ctrl_o.lo_op = OP_ADD; ctrl_o.hi_op = OP_ADD; ctrl_o.src = SRC_CHAIN; end
            M_ADD_HI_P1:   begin ctrl_o.hi_op = OP_ADD; ctrl_o.src = SRC_LO_A; end
            M_ADD_HI_CI:   begin ctrl_o.hi_op = OP_ADD; ctrl_o.src = SRC_CHAIN; end
            M_ADD_HI_NP3:  begin ctrl_o.hi_op = OP_ADD; ctrl_o.src = SRC_NCTL; end

            M_SUB_LO_CI:   begin ctrl_o.lo_op = OP_SUB; ctrl_o.src = SRC_CHAIN; end
            M_SUB_PAIR_CI: begin ctrl_o.lo_op = OP_SUB; ctrl_o.hi_op = OP_SUB; ctrl_o.src = SRC_CHAIN; end
            M_SUB_HI_ONE:  begin ctrl_o.hi_op = OP_SUB; ctrl_o.src = SRC_ONE; ctrl_o.hi_int = 1'b1; end
            M_SUB_HI_CI:   begin ctrl_o.hi_op = OP_SUB; ctrl_o.src = SRC_CHAIN; end
            M_SUB_HI_P1:   begin ctrl_o.hi_op = OP_SUB; ctrl_o.src = SRC_LO_A; end
            M_SUB_HI_NP3:  begin ctrl_o.hi_op = OP_SUB; ctrl_o.src = SRC_NCTL; end

            M_ADS_LO_CI:   begin ctrl_o.lo_op = OP_ADS; ctrl_o.src = SRC_CHAIN; end
            M_ADS_PAIR_CI: begin ctrl_o.lo_op = OP_ADS; ctrl_o.hi_op = OP_ADS; ctrl_o.src = SRC_CHAIN; end
            M_ADS_HI_CI:   begin ctrl_o.hi_op = OP_ADS; ctrl_o.src = SRC_CHAIN; end
            M_ADS_HI_P1:   begin ctrl_o.hi_op = OP_ADS; ctrl_o.src = SRC_LO_A; end
            M_ADS_HI_NP3:  begin
                ctrl_o.hi_op = OP_ADS; ctrl_o.src = SRC_NCTL;
                ctrl_o.hi_int = 1'b1; ctrl_o.hi_m_lo = 1'b1;
            end

            M_INC_LO_CI:   begin ctrl_o.lo_op = OP_INC; ctrl_o.src = SRC_CHAIN; end
            M_INC_PAIR_1:  begin
                ctrl_o.lo_op = OP_INC; ctrl_o.hi_op = OP_INC;
                ctrl_o.src = SRC_ONE; ctrl_o.lo_int = 1'b1;
            end
            M_INC_PAIR_CI: begin ctrl_o.lo_op = OP_INC; ctrl_o.hi_op = OP_INC; ctrl_o.src = SRC_CHAIN; end
            M_INC_HI_CI:   begin ctrl_o.hi_op = OP_INC; ctrl_o.src = SRC_CHAIN; end
            M_INC_HI_P1:   begin ctrl_o.hi_op = OP_INC; ctrl_o.src = SRC_LO_A; end
            M_INC_HI_NP3:  begin ctrl_o.hi_op = OP_INC; ctrl_o.src = SRC_NCTL; end

            M_DEC_LO_CI:   begin ctrl_o.lo_op = OP_DEC; ctrl_o.src = SRC_CHAIN; end
            M_DEC_PAIR_0:  begin
                ctrl_o.lo_op = OP_DEC; ctrl_o.hi_op = OP_DEC;
                ctrl_o.src = SRC_ZERO; ctrl_o.lo_int = 1'b1;
            end
            M_DEC_PAIR_CI: begin ctrl_o.lo_op = OP_DEC; ctrl_o.hi_op = OP_DEC; ctrl_o.src = SRC_CHAIN; end
            M_DEC_HI_CI:   begin ctrl_o.hi_op = OP_DEC; ctrl_o.src = SRC_CHAIN; end
            M_DEC_HI_P1:   begin ctrl_o.hi_op = OP_DEC; ctrl_o.src = SRC_LO_A; end
            M_DEC_HI_NP3:  begin ctrl_o.hi_op = OP_DEC; ctrl_o.src = SRC_NCTL; end

            // The three always-enabled one-bit modes share one decrement-with-zero form
            M_INC_HI_ONE, M_DEC_HI_ZERO, M_IDC_HI_ZERO: begin
                ctrl_o.hi_op = OP_DEC; ctrl_o.src = SRC_ZERO; ctrl_o.hi_int = 1'b1;
            end

            M_IDC_LO_CI:   begin ctrl_o.lo_op = OP_IDC; ctrl_o.src = SRC_CHAIN; end
            M_IDC_PAIR_EN: begin
                ctrl_o.lo_op = OP_IDC; ctrl_o.hi_op = OP_IDC;
                ctrl_o.src = SRC_CTL; ctrl_o.lo_int = 1'b1;
            end
            M_IDC_PAIR_CI: begin ctrl_o.lo_op = OP_IDC; ctrl_o.hi_op = OP_IDC; ctrl_o.src = SRC_CHAIN; end
            M_IDC_HI_CI:   begin ctrl_o.hi_op = OP_IDC; ctrl_o.src = SRC_CHAIN; end
            M_IDC_HI_P1:   begin ctrl_o.hi_op = OP_IDC; ctrl_o.src = SRC_LO_A; end

            M_PASS_ZERO:   ctrl_o.src = SRC_ZERO;
            M_PASS_ONE:    ctrl_o.src = SRC_ONE;
            M_PASS_CI,
            M_PEEK_CI:     ctrl_o.src = SRC_CHAIN;
            M_PASS_P1:     ctrl_o.src = SRC_LO_A;
            M_PASS_NP3:    ctrl_o.src = SRC_NCTL;
            M_PASS_HI_A:   begin ctrl_o.src = SRC_ZERO; ctrl_o.out_hi_a = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/dcs_carry_src.sv
module dcs_carry_src
    import dcs_pkg::*;
(
    input  src_e src_i,
    input  logic chain_i,
    input  logic lo_a_i,
    input  logic lo_ctl_i,
    output logic carry_o
);

    always_comb begin
        case (src_i)
            SRC_CHAIN: carry_o = chain_i;
            SRC_LO_A:  carry_o = lo_a_i;
            SRC_NCTL:  carry_o = ~lo_ctl_i;
            SRC_CTL:   carry_o = lo_ctl_i;
            SRC_ONE:   carry_o = 1'b1;
            default:   carry_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcs_bit_slice.sv
module dcs_bit_slice
    import dcs_pkg::*;
(
    input  op_e  op_i,
    input  logic a_i,
    input  logic b_i,
    input  logic pin_i,      // routing-pin carry term for the result
    input  logic c_i,        // internal carry into this bit
    input  logic sum_ctl_i,  // direction seen by the result logic
    input  logic dir_i,      // direction seen by the carry logic
    input  logic use_int_i,
    output logic s_o,
    output logic co_o
);

    logic t;
    logic add_co;
    logic sub_co;

    always_comb begin
        t      = use_int_i ? c_i : pin_i;
        add_co = (a_i & b_i) | (c_i & (a_i | b_i));
        sub_co = (a_i & ~b_i) | (c_i & (a_i | ~b_i));
        s_o    = 1'b0;
        co_o   = c_i;
        case (op_i)
            OP_ADD: begin s_o = a_i ^ b_i ^ t;               co_o = add_co; end
            OP_SUB: begin s_o = ~(a_i ^ b_i ^ t);            co_o = sub_co; end
            OP_ADS: begin s_o = ~(a_i ^ b_i ^ t ^ sum_ctl_i); co_o = dir_i ? add_co : sub_co; end
            OP_INC: begin s_o = a_i ^ t;                     co_o = a_i & c_i; end
            OP_DEC: begin s_o = ~(a_i ^ t);                  co_o = a_i | c_i; end
            OP_IDC: begin
                s_o  = a_i ^ t ^ ~sum_ctl_i;
                co_o = dir_i ? (a_i & c_i) : (a_i | c_i);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dual_carry_slice.sv
module dual_carry_slice
    import dcs_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              chain_in,
    input  logic              lo_a,
    input  logic              lo_b,
    input  logic              lo_ctl,
    input  logic              lo_sum_c,
    input  logic              hi_a,
    input  logic              hi_b,
    input  logic              hi_ctl,
    input  logic              hi_sum_c,
    output logic              lo_out,
    output logic              hi_out,
    output logic              mid_carry,
    output logic              chain_out
);

    ctrl_t             ctrl;
    logic              src_c;
    logic [N_HALF-1:0] a_v, b_v, p_v, m_v, int_v, s_v, ci_v, co_v;
    op_e               op_v [N_HALF];
    res_t              res_d;

    dcs_mode_decode u_decode (
        .mode_i (mode),
        .ctrl_o (ctrl)
    );

    dcs_carry_src u_src (
        .src_i    (ctrl.src),
        .chain_i  (chain_in),
        .lo_a_i   (lo_a),
        .lo_ctl_i (lo_ctl),
        .carry_o  (src_c)
    );

    assign a_v   = {hi_a, lo_a};
    assign b_v   = {hi_b, lo_b};
    assign p_v   = {hi_sum_c, lo_sum_c};
    assign m_v   = {(ctrl.hi_m_lo ? lo_ctl : hi_ctl), lo_ctl};
    assign int_v = {ctrl.hi_int, ctrl.lo_int};
    assign op_v[0] = ctrl.lo_op;
    assign op_v[1] = ctrl.hi_op;

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        if (i == 0) begin : g_first
            assign ci_v[i] = src_c;
        end else begin : g_next
            assign ci_v[i] = co_v[i-1];
        end
        dcs_bit_slice u_slice (
            .op_i      (op_v[i]),
            .a_i       (a_v[i]),
            .b_i       (b_v[i]),
            .pin_i     (p_v[i]),
            .c_i       (ci_v[i]),
            .sum_ctl_i (m_v[i]),
            .dir_i     (lo_ctl),
            .use_int_i (int_v[i]),
            .s_o       (s_v[i]),
            .co_o      (co_v[i])
        );
    end

    always_comb begin
        res_d.lo_out = s_v[0];
        res_d.hi_out = s_v[N_HALF-1];
        res_d.mid    = co_v[0];
        res_d.chain  = ctrl.out_hi_a ? hi_a : co_v[N_HALF-1];
    end

    assign lo_out    = res_d.lo_out;
    assign hi_out    = res_d.hi_out;
    assign mid_carry = res_d.mid;
    assign chain_out = res_d.chain;

endmodule

// File: rtl/dual_carry_slice_chk.sv
module dual_carry_slice_chk (
    input logic [5:0] mode,
    input logic       chain_in,
    input logic       lo_a,
    input logic       lo_b,
    input logic       lo_ctl,
    input logic       lo_sum_c,
    input logic       hi_a,
    input logic       hi_b,
    input logic       hi_sum_c,
    input logic       lo_out,
    input logic       hi_out,
    input logic       mid_carry,
    input logic       chain_out
);

    logic [2:0] sum_add;
    logic [2:0] sum_sub;

    always_comb begin
        sum_add = {1'b0, hi_a, lo_a} + {1'b0, hi_b, lo_b} + {2'b00, chain_in};
        sum_sub = {1'b0, hi_a, lo_a} + {1'b0, ~hi_b, ~lo_b} + {2'b00, chain_in};

        // R1: two-bit add with routing pins tied as a user would
        if (mode == 6'd1 && lo_sum_c == chain_in && hi_sum_c == mid_carry)
            a_r1_pair_add: assert ({chain_out, hi_out, lo_out} == sum_add)
                else $error("a_r1_pair_add");

        // R2: two-bit subtract, carry-out 1 meaning no borrow
        if (mode == 6'd6 && lo_sum_c == chain_in && hi_sum_c == mid_carry)
            a_r2_pair_sub: assert ({chain_out, hi_out, lo_out} == sum_sub)
                else $error("a_r2_pair_sub");

        // R7: upper-only mode sourced from the lower A pin
        if (mode == 6'd2 || mode == 6'd9 || mode == 6'd21 || mode == 6'd28)
            a_r7_src_lo_a: assert (mid_carry == lo_a)
                else $error("a_r7_src_lo_a");

        // R8: pass-through of the chain carry
        if (mode == 6'd38 || mode == 6'd42)
            a_r8_pass_chain: assert (mid_carry == chain_in && chain_out == chain_in
                                     && !lo_out && !hi_out)
                else $error("a_r8_pass_chain");

        // R8: upper-A pass-through
        if (mode == 6'd41)
            a_r8_pass_hi_a: assert (chain_out == hi_a && !mid_carry)
                else $error("a_r8_pass_hi_a");

        // R9: always-enabled one-bit modes
        if (mode == 6'd19 || mode == 6'd26 || mode == 6'd33)
            a_r9_lsb_same: assert (hi_out == ~hi_a && chain_out == hi_a && !mid_carry)
                else $error("a_r9_lsb_same");

        // R10: lower-only modes leave the upper result at 0
        if (mode == 6'd0 || mode == 6'd5 || mode == 6'd11 || mode == 6'd16
            || mode == 6'd23 || mode == 6'd30)
            a_r10_hi_idle: assert (!hi_out && chain_out == mid_carry)
                else $error("a_r10_hi_idle");

        // R11: unassigned codes
        if (mode > 6'd42)
            a_r11_illegal: assert (!lo_out && !hi_out && !mid_carry && !chain_out)
                else $error("a_r11_illegal");
    end

endmodule

bind dual_carry_slice dual_carry_slice_chk i_chk (
    .mode      (mode),
    .chain_in  (chain_in),
    .lo_a      (lo_a),
    .lo_b      (lo_b),
    .lo_ctl    (lo_ctl),
    .lo_sum_c  (lo_sum_c),
    .hi_a      (hi_a),
    .hi_b      (hi_b),
    .hi_sum_c  (hi_sum_c),
    .lo_out    (lo_out),
    .hi_out    (hi_out),
    .mid_carry (mid_carry),
    .chain_out (chain_out)
);

// File: tb/test_dual_carry_slice.sv
module test_dual_carry_slice;

    logic       clk = 1'b0;
    logic [5:0] mode = '0;
    logic       chain_in = 0, lo_a = 0, lo_b = 0, lo_ctl = 0, lo_sum_c = 0;
    logic       hi_a = 0, hi_b = 0, hi_ctl = 0, hi_sum_c = 0;
    logic       lo_out, hi_out, mid_carry, chain_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    typedef struct {
        logic [5:0] m;
        logic [8:0] v;
        logic [3:0] exp;   // {lo_out, hi_out, mid_carry, chain_out}
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    dual_carry_slice i_dual_carry_slice (
        .mode(mode), .chain_in(chain_in), .lo_a(lo_a), .lo_b(lo_b),
        .lo_ctl(lo_ctl), .lo_sum_c(lo_sum_c), .hi_a(hi_a), .hi_b(hi_b),
        .hi_ctl(hi_ctl), .hi_sum_c(hi_sum_c), .lo_out(lo_out),
        .hi_out(hi_out), .mid_carry(mid_carry), .chain_out(chain_out)
    );

    function automatic logic cy_add(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x | y));
    endfunction

    function automatic logic cy_sub(input logic x, input logic y, input logic c);
        return (x & ~y) | (c & (x | ~y));
    endfunction

    // Reference written from the per-mode equations of the requirements.
    // v = {chain_in, hi_sum_c, hi_ctl, hi_b, hi_a, lo_sum_c, lo_ctl, lo_b, lo_a}
    function automatic logic [3:0] ref_model(input logic [5:0] m, input logic [8:0] v);
        logic la, lb, lc, lp, ha, hb, hc, hp, ci, f, g, c0, co;
        {ci, hp, hc, hb, ha, lp, lc, lb, la} = v;
        f = 0; g = 0; c0 = 0; co = 0;
        case (m)
            6'd0:  begin f = la^lb^lp; c0 = cy_add(la,lb,ci); co = c0; end
            6'd1:  begin f = la^lb^lp; c0 = cy_add(la,lb,ci); g = ha^hb^hp; co = cy_add(ha,hb,c0); end
            6'd2:  begin c0 = la;  g = ha^hb^hp; co = cy_add(ha,hb,c0); end
            6'd3:  begin c0 = ci;  g = ha^hb^hp; co = cy_add(ha,hb,c0); end
            6'd4:  begin c0 = ~lc; g = ha^hb^hp; co = cy_add(ha,hb,c0); end
            6'd5:  begin f = ~(la^lb^lp); c0 = cy_sub(la,lb,ci); co = c0; end
            6'd6:  begin f = ~(la^lb^lp); c0 = cy_sub(la,lb,ci); g = ~(ha^hb^hp); co = cy_sub(ha,hb,c0); end
            6'd7:  begin c0 = 1;   g = ha^hb; co = ha | ~hb; end
            6'd8:  begin c0 = ci;  g = ~(ha^hb^hp); co = cy_sub(ha,hb,c0); end
            6'd9:  begin c0 = la;  g = ~(ha^hb^hp); co = cy_sub(ha,hb,c0); end
            6'd10: begin c0 = ~lc; g = ~(ha^hb^hp); co = cy_sub(ha,hb,c0); end
            6'd11: begin f = ~(la^lb^lp^lc); c0 = lc ? cy_add(la,lb,ci) : cy_sub(la,lb,ci); co = c0; end
            6'd12: begin
                f = ~(la^lb^lp^lc); c0 = lc ? cy_add(la,lb,ci) : cy_sub(la,lb,ci);
                g = ~(ha^hb^hp^hc); co = lc ? cy_add(ha,hb,c0) : cy_sub(ha,hb,c0);
            end
            6'd13: begin c0 = ci; g = ~(ha^hb^hp^hc); co = lc ? cy_add(ha,hb,c0) : cy_sub(ha,hb,c0); end
            6'd14: begin c0 = la; g = ~(ha^hb^hp^hc); co = lc ? cy_add(ha,hb,c0) : cy_sub(ha,hb,c0); end
            6'd15: begin c0 = ~lc; g = ha^hb; co = lc ? (ha & hb) : (ha | ~hb); end
            6'd16: begin f = la^lp; c0 = ci & la; co = c0; end
            6'd17: begin f = ~la; c0 = la; g = hp^ha; co = c0 & ha; end
            6'd18: begin f = la^lp; c0 = ci & la; g = ha^hp; co = c0 & ha; end
            6'd19, 6'd26, 6'd33: begin c0 = 0; g = ~ha; co = ha; end
            6'd20: begin c0 = ci;  g = ha^hp; co = c0 & ha; end
            6'd21: begin c0 = la;  g = ha^hp; co = c0 & ha; end
            6'd22: begin c0 = ~lc; g = ha^hp; co = c0 & ha; end
            6'd23: begin f = ~(la^lp); c0 = la | ci; co = c0; end
            6'd24: begin f = ~la; c0 = la; g = ~(ha^hp); co = ha | c0; end
            6'd25: begin f = ~(la^lp); c0 = la | ci; g = ~(ha^hp); co = ha | c0; end
            6'd27: begin c0 = ci;  g = ~(ha^hp); co = ha | c0; end
            6'd28: begin c0 = la;  g = ~(ha^hp); co = ha | c0; end
            6'd29: begin c0 = ~lc; g = ~(ha^hp); co = ha | c0; end
            6'd30: begin f = la^lp^~lc; c0 = lc ? (la & ci) : (la | ci); co = c0; end
            6'd31: begin f = ~la; c0 = la; g = hp^ha^~hc; co = lc ? (ha & c0) : (ha | c0); end
            6'd32: begin
                f = la^lp^~lc; c0 = lc ? (la & ci) : (la | ci);
                g = ha^hp^~hc;  co = lc ? (ha & c0) : (ha | c0);
            end
            6'd34: begin c0 = ci; g = ha^hp^~hc; co = lc ? (ha & c0) : (ha | c0); end
            6'd35: begin c0 = la; g = ha^hp^~hc; co = lc ? (ha & c0) : (ha | c0); end
            6'd36: begin c0 = 0;   co = 0; end
            6'd37: begin c0 = 1;   co = 1; end
            6'd38, 6'd42: begin c0 = ci; co = ci; end
            6'd39: begin c0 = la;  co = la; end
            6'd40: begin c0 = ~lc; co = ~lc; end
            6'd41: begin c0 = 0;   co = ha; end
            default: ;
        endcase
        return {f, g, c0, co};
    endfunction

    function automatic string fam_tag(input logic [5:0] m);
        if (m == 6'd19 || m == 6'd26 || m == 6'd33) return "R9";
        if (m <= 6'd4)  return "R1";
        if (m <= 6'd10) return "R2";
        if (m <= 6'd15) return "R3";
        if (m <= 6'd22) return "R4";
        if (m <= 6'd29) return "R5";
        if (m <= 6'd35) return "R6";
        if (m <= 6'd42) return "R8";
        return "R11";
    endfunction

    function automatic bit lo_only(input logic [5:0] m);
        return m == 6'd0 || m == 6'd5 || m == 6'd11 || m == 6'd16 || m == 6'd23 || m == 6'd30;
    endfunction

    function automatic bit hi_only(input logic [5:0] m);
        return (m >= 6'd2 && m <= 6'd4) || (m >= 6'd7 && m <= 6'd10) || (m >= 6'd13 && m <= 6'd15)
            || (m >= 6'd19 && m <= 6'd22) || (m >= 6'd26 && m <= 6'd29) || (m >= 6'd33 && m <= 6'd35);
    endfunction

    task automatic check_bit(input string tag, input string name, input item_t it,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s mode=%0d in=%b actual=%b expected=%b",
                     tag, name, it.m, it.v, act, exp);
        end
    endtask

    // Driver: apply one vector per cycle and push its expectation
    task automatic drive(input logic [5:0] m, input logic [8:0] v);
        item_t it;
        @(posedge clk);
        #1;
        mode = m;
        {chain_in, hi_sum_c, hi_ctl, hi_b, hi_a, lo_sum_c, lo_ctl, lo_b, lo_a} = v;
        it.m = m; it.v = v; it.exp = ref_model(m, v);
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, half a cycle after the drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            string t_lo, t_hi, t_co;
            it = sb_q.pop_front();
            t_lo = hi_only(it.m) ? "R10" : fam_tag(it.m);
            t_hi = lo_only(it.m) ? "R10" : fam_tag(it.m);
            t_co = lo_only(it.m) ? "R7"  : fam_tag(it.m);
            check_bit(t_lo,  "lo_out",    it, lo_out,    it.exp[3]);
            check_bit(t_hi,  "hi_out",    it, hi_out,    it.exp[2]);
            check_bit("R7",  "mid_carry", it, mid_carry, it.exp[1]);   // carry source
            check_bit(t_co,  "chain_out", it, chain_out, it.exp[0]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 40000 && !done) begin
            failures++;
            checks++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Idle state with all inputs low, mode 0 (R1): every output 0
        #5;
        checks++;
        if ({lo_out, hi_out, mid_carry, chain_out} !== 4'b0000) begin
            failures++;
            $display("FAIL R1 idle actual=%b expected=0000",
                     {lo_out, hi_out, mid_carry, chain_out});
        end
        // Full sweep: every code (R1-related families through R11 unassigned codes)
        // against all 512 data patterns, including mismatched routing pins
        for (int m = 0; m < 64; m++) begin
            for (int v = 0; v < 512; v++) begin
                drive(6'(m), 9'(v));
            end
        end
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule